// File: doc/BRIEF.md
# ROM Configuration Table Enumerator

This block reads a configuration table held in a byte-wide synchronous memory and turns it into a per-chip map of a flash array. The flash is divided into eight 16KB chips. Each table entry is eight bytes long, and each entry claims one or more of these chips. Entries are processed in table order. Each chip gets four things from the walk:
- a kind: free, enumerated, ignored or hard-wired;
- the logical ROM it belongs to;
- its slot in the enumeration sequence;
- a sticky error flag for malformed entries.

A single-cycle `start` launches a walk. The block issues one read per table byte, one entry after another, and applies each decoded entry to the chip records. It then raises `done` for one cycle. The records stay on the outputs until the next walk begins, so downstream address-decode logic can use them directly. An entry may set a stop flag to end normal enumeration. After that point, ordinary entries only mark their chips as ignored. Hard-wired entries for the two top chips are still accepted after the stop.

Top module: `rom_enum_walker`

## Requirements
- R1: A walk reads entry k from table addresses TBL_BASE+8k to TBL_BASE+8k+7, in ascending order, one read per byte. The byte meanings are, in order: size code, reserved, type, class, last marker, flag, address, chip number. No read is issued while the block is idle.
- R2: An entry with flag 0x00 or 0x01 is applied while enumeration is running. Its size code sets how many consecutive chips it covers, starting at its chip number: 0x0A covers 1 chip, 0x09 covers 2 and 0x08 covers 4. Those chips get kind code 1 (enumerated). Kind codes are: 0 free, 1 enumerated, 2 ignored, 3 hard-wired.
- R3: Enumerated chips get the current logical ROM id, which starts at 0. The id advances after an enumerated entry whose last marker is 0x08. A last marker of 0x00 keeps the next entry in the same ROM.
- R4: Enumerated chips get slot numbers counting from 0 in table order. The chips of one entry get consecutive slots.
- R5: Flag 0x01 stops enumeration after its own entry is applied. A later entry with flag 0x00 or 0x01 changes its chip to kind 2 (ignored) only if that chip is free. A chip that is already enumerated stays enumerated.
- R6: Flag 0x02 on chip 6 or 7 gives kind 3 (hard-wired) to every chip the entry covers. This holds both before and after a stop. Hard-wired and ignored chips report ROM id 0 and slot 0. Hard-wired entries do not advance the ROM id or the slot count.
- R7: The entry raises the error output and maps nothing in any of these cases:
  - flag 0x02 on any chip other than 6 or 7;
  - a flag value above 0x02;
  - an unknown size code;
  - a chip number above 7;
  - a span that runs past chip 7.
- R8: The address byte of an entry has no effect on any output.
- R9: The walk ends at the first entry whose class byte is 0x0C, without applying that entry, or after 16 entries. No table byte beyond that point is read.
- R10: An accepted `start` clears all chip records and the error flag. `busy` is high during the walk. `done` is high for exactly one cycle when the results are valid. The results are held until the next accepted `start`. A `start` while `busy` is ignored.
- R11: After reset, every chip is free, error, `busy` and `done` are low, and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a table walk |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | TBL_AW | Table byte address |
| tbl_rd_data | input | 8 | Table byte, one cycle after the strobe |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| cfg_err | output | 1 | A malformed entry was seen during the walk |
| chip_kind | output | 2*NCHIP | Kind code per chip, chip i at bits [2i+1:2i] |
| chip_rom | output | CHIP_W*NCHIP | Logical ROM id per chip |
| chip_slot | output | CHIP_W*NCHIP | Enumeration slot per chip |

## Verification
The hardest case to reach is a table in which the stop flag has already been seen and later entries try to touch chips. Such a table mixes a repeated entry for a chip that is already enumerated, an ordinary entry for a free chip, and hard-wired entries for legal and illegal chips. Stimulus vectors build tables of this kind and check every chip's kind, ROM id and slot. Directed runs cover the remaining boundaries:
- a table with no terminator, to reach the sixteen-entry limit;
- a terminator in the first entry;
- a second `start` in the middle of a walk;
- a repeat walk with altered address bytes.

// File: rtl/rom_enum_pkg.sv
package rom_enum_pkg;

  typedef struct packed {
    logic [7:0] size_code;
    logic [7:0] resv;
    logic [7:0] dtype;
    logic [7:0] cls;
    logic [7:0] last;
    logic [7:0] flag;
    logic [7:0] addr;
    logic [7:0] chip;
  } tbl_ent_t;

  typedef enum logic [1:0] {
    CK_FREE = 2'd0,
    CK_ENUM = 2'd1,
    CK_SKIP = 2'd2,
    CK_HARD = 2'd3
  } chip_kind_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ENUM = 2'd1,
    CMD_SKIP = 2'd2,
    CMD_HARD = 2'd3
  } ent_cmd_e;

  localparam logic [7:0] SZ_16K     = 8'h0A;
  localparam logic [7:0] SZ_32K     = 8'h09;
  localparam logic [7:0] SZ_64K     = 8'h08;
  localparam logic [7:0] LAST_END   = 8'h08;
  localparam logic [7:0] FLAG_GO    = 8'h00;
  localparam logic [7:0] FLAG_STOP  = 8'h01;
  localparam logic [7:0] FLAG_HARD  = 8'h02;
  localparam logic [7:0] CLASS_MMIO = 8'h0C;
  localparam int         ENT_BYTES  = 8;

endpackage

// File: rtl/rom_tbl_fetch.sv
module rom_tbl_fetch
  import rom_enum_pkg::*;
#(
  parameter int TBL_AW   = 8,
  parameter int TBL_BASE = 0,
  parameter int ENT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ENT_W-1:0]  ent_idx,
  output logic              rd_en,
  output logic [TBL_AW-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output tbl_ent_t          ent,
  output logic              ent_vld
);

  localparam int BYTE_W = $clog2(ENT_BYTES);

  logic              issuing_q;
  logic [BYTE_W-1:0] iss_q;
  logic              pend_q;
  logic [BYTE_W-1:0] pend_idx_q;
  logic [63:0]       ent_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing_q  <= 1'b0;
      iss_q      <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      ent_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (go) begin
        issuing_q <= 1'b1;
        iss_q     <= '0;
      end else if (issuing_q) begin
        iss_q <= iss_q + 1'b1;
        if (iss_q == BYTE_W'(ENT_BYTES - 1)) issuing_q <= 1'b0;
      end
      pend_q     <= issuing_q;
      pend_idx_q <= iss_q;
      if (pend_q) begin
        // byte k of the entry lands at the k-th most significant byte
        ent_q[{~pend_idx_q, 3'b000} +: 8] <= rd_data;
        if (pend_idx_q == BYTE_W'(ENT_BYTES - 1)) vld_q <= 1'b1;
      end
    end
  end

  assign rd_en   = issuing_q;
  assign rd_addr = TBL_AW'(TBL_BASE) + TBL_AW'({ent_idx, iss_q});
  assign ent     = tbl_ent_t'(ent_q);
  assign ent_vld = vld_q;

  // R1: back-to-back reads walk the table one byte at a time
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + TBL_AW'(1)));

endmodule

// File: rtl/rom_ent_decode.sv
module rom_ent_decode
  import rom_enum_pkg::*;
#(
  parameter int NCHIP  = 8,
  parameter int HW_A   = 6,
  parameter int HW_B   = 7,
  parameter int CHIP_W = 3
) (
  input  tbl_ent_t          ent,
  input  logic              stopped,
  output ent_cmd_e          cmd,
  output logic [CHIP_W-1:0] cmd_chip,
  output logic [CHIP_W+1:0] cmd_span,
  output logic              cmd_err,
  output logic              cmd_stop,
  output logic              cmd_last,
  output logic              is_mmio
);

  logic [CHIP_W+1:0] span;
  logic              size_ok;
  logic              chip_ok;
  logic              fit_ok;
  logic              hw_chip;
  logic              unused_fields;

  assign unused_fields = ^{ent.resv, ent.dtype, ent.addr};

  always_comb begin
    size_ok = 1'b1;
    case (ent.size_code)
      SZ_16K:  span = (CHIP_W+2)'(1);
      SZ_32K:  span = (CHIP_W+2)'(2);
      SZ_64K:  span = (CHIP_W+2)'(4);
      default: begin
        span    = '0;
        size_ok = 1'b0;
      end
    endcase
  end

  assign chip_ok  = ent.chip < 8'(NCHIP);
  assign fit_ok   = ({1'b0, ent.chip} + 9'(span)) <= 9'(NCHIP);
  assign hw_chip  = chip_ok && ((ent.chip == 8'(HW_A)) || (ent.chip == 8'(HW_B)));
  assign cmd_chip = ent.chip[CHIP_W-1:0];
  assign cmd_last = ent.last == LAST_END;
  assign is_mmio  = ent.cls == CLASS_MMIO;

  always_comb begin
    cmd      = CMD_NONE;
    cmd_span = '0;
    cmd_err  = 1'b0;
    cmd_stop = 1'b0;
    case (ent.flag)
      FLAG_HARD: begin
        if (hw_chip && size_ok && fit_ok) begin
          cmd      = CMD_HARD;
          cmd_span = span;
        end else begin
          cmd_err = 1'b1;
        end
      end
      FLAG_GO, FLAG_STOP: begin
        if (stopped) begin
          if (chip_ok) begin
            cmd      = CMD_SKIP;
            cmd_span = (CHIP_W+2)'(1);
          end
        end else begin
          cmd_stop = ent.flag == FLAG_STOP;
          if (size_ok && chip_ok && fit_ok) begin
            cmd      = CMD_ENUM;
            cmd_span = span;
          end else begin
            cmd_err = 1'b1;
          end
        end
      end
      default: cmd_err = 1'b1;
    endcase
  end

endmodule

// File: rtl/rom_chip_map.sv
module rom_chip_map
  import rom_enum_pkg::*;
#(
  parameter int NCHIP  = 8,
  parameter int HW_A   = 6,
  parameter int HW_B   = 7,
  parameter int CHIP_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     apply,
  input  ent_cmd_e                 cmd,
  input  logic [CHIP_W-1:0]        cmd_chip,
  input  logic [CHIP_W+1:0]        cmd_span,
  input  logic                     cmd_err,
  input  logic                     cmd_stop,
  input  logic                     cmd_last,
  output logic                     stopped,
  output logic                     err,
  output logic [2*NCHIP-1:0]       kind_o,
  output logic [CHIP_W*NCHIP-1:0]  rom_o,
  output logic [CHIP_W*NCHIP-1:0]  slot_o
);

  logic              stopped_q;
  logic              err_q;
  logic [CHIP_W:0]   rom_cnt_q;
  logic [CHIP_W:0]   slot_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      stopped_q  <= 1'b0;
      err_q      <= 1'b0;
      rom_cnt_q  <= '0;
      slot_cnt_q <= '0;
    end else if (apply) begin
      err_q <= err_q | cmd_err;
      if (cmd_stop) stopped_q <= 1'b1;
      if (cmd == CMD_ENUM) begin
        slot_cnt_q <= slot_cnt_q + cmd_span[CHIP_W:0];
        if (cmd_last) rom_cnt_q <= rom_cnt_q + 1'b1;
      end
    end
  end

  assign stopped = stopped_q;
  assign err     = err_q;

  for (genvar i = 0; i < NCHIP; i++) begin : g_chip
    localparam logic [CHIP_W+1:0] IDX = (CHIP_W+2)'(i);

    chip_kind_e        kind_q;
    logic [CHIP_W-1:0] rom_q;
    logic [CHIP_W-1:0] slot_q;
    logic              hit;
    logic [CHIP_W+1:0] slot_sum;

    assign hit      = (IDX >= {2'b00, cmd_chip}) && (IDX < ({2'b00, cmd_chip} + cmd_span));
    assign slot_sum = {1'b0, slot_cnt_q} + IDX - {2'b00, cmd_chip};

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        kind_q <= CK_FREE;
        rom_q  <= '0;
        slot_q <= '0;
      end else if (apply && hit) begin
        case (cmd)
          CMD_ENUM: begin
            kind_q <= CK_ENUM;
            rom_q  <= rom_cnt_q[CHIP_W-1:0];
            slot_q <= slot_sum[CHIP_W-1:0];
          end
          CMD_SKIP: begin
            if (kind_q == CK_FREE) kind_q <= CK_SKIP;
          end
          CMD_HARD: begin
            kind_q <= CK_HARD;
            rom_q  <= '0;
            slot_q <= '0;
          end
          default: ;
        endcase
      end
    end

    assign kind_o[2*i +: 2]          = kind_q;
    assign rom_o[CHIP_W*i +: CHIP_W]  = rom_q;
    assign slot_o[CHIP_W*i +: CHIP_W] = slot_q;

    if ((i != HW_A) && (i != HW_B)) begin : g_chk
      // R6/R7: only the two top chips can ever become hard-wired
      assert_hard_only_top_R6: assert property (@(posedge clk) disable iff (rst)
        kind_q != CK_HARD);
    end
  end

endmodule

// File: rtl/rom_enum_walker.sv
module rom_enum_walker
  import rom_enum_pkg::*;
#(
  parameter int NCHIP    = 8,
  parameter int MAX_ENT  = 16,
  parameter int TBL_AW   = 8,
  parameter int TBL_BASE = 0,
  parameter int HW_A     = 6,
  parameter int HW_B     = 7,
  localparam int CHIP_W  = $clog2(NCHIP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     tbl_rd_en,
  output logic [TBL_AW-1:0]        tbl_rd_addr,
  input  logic [7:0]               tbl_rd_data,
  output logic                     busy,
  output logic                     done,
  output logic                     cfg_err,
  output logic [2*NCHIP-1:0]       chip_kind,
  output logic [CHIP_W*NCHIP-1:0]  chip_rom,
  output logic [CHIP_W*NCHIP-1:0]  chip_slot
);

  localparam int ENT_W = $clog2(MAX_ENT);

  logic             busy_q;
  logic             done_q;
  logic             go_q;
  logic [ENT_W-1:0] idx_q;
  logic             launch;
  logic             apply;
  logic             finish;

  tbl_ent_t          ent;
  logic              ent_vld;
  ent_cmd_e          cmd;
  logic [CHIP_W-1:0] cmd_chip;
  logic [CHIP_W+1:0] cmd_span;
  logic              cmd_err;
  logic              cmd_stop;
  logic              cmd_last;
  logic              is_mmio;
  logic              stopped;

  assign launch = start && !busy_q;
  assign apply  = busy_q && ent_vld && !is_mmio;
  assign finish = busy_q && ent_vld && (is_mmio || (idx_q == ENT_W'(MAX_ENT - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      go_q   <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      go_q   <= 1'b0;
      if (launch) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        go_q   <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q && ent_vld) begin
        idx_q <= idx_q + 1'b1;
        go_q  <= 1'b1;
      end
    end
  end

  rom_tbl_fetch #(
    .TBL_AW  (TBL_AW),
    .TBL_BASE(TBL_BASE),
    .ENT_W   (ENT_W)
  ) u_fetch (
    .clk    (clk),
    .rst    (rst),
    .go     (go_q),
    .ent_idx(idx_q),
    .rd_en  (tbl_rd_en),
    .rd_addr(tbl_rd_addr),
    .rd_data(tbl_rd_data),
    .ent    (ent),
    .ent_vld(ent_vld)
  );

  rom_ent_decode #(
    .NCHIP (NCHIP),
    .HW_A  (HW_A),
    .HW_B  (HW_B),
    .CHIP_W(CHIP_W)
  ) u_decode (
    .ent     (ent),
    .stopped (stopped),
    .cmd     (cmd),
    .cmd_chip(cmd_chip),
    .cmd_span(cmd_span),
    .cmd_err (cmd_err),
    .cmd_stop(cmd_stop),
    .cmd_last(cmd_last),
    .is_mmio (is_mmio)
  );

  rom_chip_map #(
    .NCHIP (NCHIP),
    .HW_A  (HW_A),
    .HW_B  (HW_B),
    .CHIP_W(CHIP_W)
  ) u_map (
    .clk     (clk),
    .rst     (rst),
    .clear   (launch),
    .apply   (apply),
    .cmd     (cmd),
    .cmd_chip(cmd_chip),
    .cmd_span(cmd_span),
    .cmd_err (cmd_err),
    .cmd_stop(cmd_stop),
    .cmd_last(cmd_last),
    .stopped (stopped),
    .err     (cfg_err),
    .kind_o  (chip_kind),
    .rom_o   (chip_rom),
    .slot_o  (chip_slot)
  );

  assign busy = busy_q;
  assign done = done_q;

  // R10: completion is a single-cycle pulse and never overlaps the walk
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R10: results are frozen while idle and no start arrives
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(chip_kind) && $stable(chip_rom) &&
                           $stable(chip_slot) && $stable(cfg_err)));
  // R1/R11: the table is only read during a walk
  assert_no_read_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tbl_rd_en);

endmodule

// File: tb/test_rom_enum_walker.sv
`timescale 1ns/1ps
module test_rom_enum_walker;

  localparam int NCHIP  = 8;
  localparam int CW     = 3;
  localparam int NV     = 4;
  localparam logic [63:0] MMIO = 64'h00_00_00_0C_02_00_00_00;

  // entry bytes: size, resv, type, class, last, flag, addr, chip
  localparam logic [63:0] ENT [NV][8] = '{
    '{64'h0A_00_01_00_08_00_00_01, 64'h09_00_01_00_08_00_5A_02,
      64'h0A_00_01_00_00_00_00_04, 64'h0A_00_01_00_08_01_00_05,
      64'h0A_00_01_00_08_00_00_05, 64'h0A_00_01_00_00_02_C3_06,
      64'h0A_00_01_00_00_02_00_07, 64'h0},
    '{64'h08_00_01_00_08_01_00_00, 64'h0A_00_01_00_08_00_00_04,
      64'h0A_00_01_00_08_02_00_03, 64'h0A_00_01_00_08_00_00_06,
      64'h0, 64'h0, 64'h0, 64'h0},
    '{64'h0A_00_01_00_00_00_00_00, 64'h0A_00_01_00_00_00_00_01,
      64'h0A_00_01_00_08_00_00_02, 64'h0B_00_01_00_08_00_00_03,
      64'h09_00_01_00_08_00_00_07, 64'h09_00_01_00_08_00_00_04,
      64'h0, 64'h0},
    '{64'h09_00_01_00_00_02_00_06, 64'h0A_00_01_00_08_00_00_00,
      64'h0A_00_01_00_08_03_00_01, 64'h0,
      64'h0, 64'h0, 64'h0, 64'h0}
  };
  localparam int NENT  [NV]    = '{7, 4, 6, 3};
  localparam int EXP_K [NV][8] = '{'{0,1,1,1,1,1,3,3}, '{1,1,1,1,2,0,2,0},
                                   '{1,1,1,0,1,1,0,0}, '{1,0,0,0,0,0,3,3}};
  localparam int EXP_R [NV][8] = '{'{0,0,1,1,2,2,0,0}, '{0,0,0,0,0,0,0,0},
                                   '{0,0,0,0,1,1,0,0}, '{0,0,0,0,0,0,0,0}};
  localparam int EXP_S [NV][8] = '{'{0,0,1,2,3,4,0,0}, '{0,1,2,3,0,0,0,0},
                                   '{0,1,2,0,3,4,0,0}, '{0,0,0,0,0,0,0,0}};
  localparam int EXP_E [NV]    = '{0, 1, 1, 1};

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  start = 1'b0;
  logic                  tbl_rd_en;
  logic [7:0]            tbl_rd_addr;
  logic [7:0]            tbl_rd_data = 8'h00;
  logic                  busy, done, cfg_err;
  logic [2*NCHIP-1:0]    chip_kind;
  logic [CW*NCHIP-1:0]   chip_rom, chip_slot;
  logic [7:0]            mem [256];

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];

  rom_enum_walker i_rom_enum_walker (
    .clk(clk), .rst(rst), .start(start),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
    .busy(busy), .done(done), .cfg_err(cfg_err),
    .chip_kind(chip_kind), .chip_rom(chip_rom), .chip_slot(chip_slot)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic put_ent(input int k, input logic [63:0] e);
    for (int b = 0; b < 8; b++) mem[8*k + b] = e[63 - 8*b -: 8];
  endtask

  task automatic wipe();
    for (int a = 0; a < 256; a++) mem[a] = 8'hFF;
  endtask

  task automatic load(input int v);
    wipe();
    for (int k = 0; k < NENT[v]; k++) put_ent(k, ENT[v][k]);
    put_ent(NENT[v], MMIO);
  endtask

  task automatic run_walk(input int extra_at, output int reads, output int dones,
                          output int last_a);
    reads = 0; dones = 0; last_a = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      start = (c == extra_at);
      if (c == extra_at) chk("R10 busy when second start arrives", busy, 1);
      if (tbl_rd_en) begin
        reads++;
        last_a = tbl_rd_addr;
      end
      if (done) begin
        dones++;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (done) dones++;
      if (tbl_rd_en) reads++;
    end
  endtask

  task automatic check_map(input string tag, input int ek[8], input int er[8],
                           input int es[8], input int ee);
    for (int i = 0; i < NCHIP; i++) begin
      chk($sformatf("R2 R5 R6 %s kind chip %0d", tag, i), chip_kind[2*i +: 2], ek[i]);
      chk($sformatf("R3 %s rom chip %0d", tag, i), chip_rom[CW*i +: CW], er[i]);
      chk($sformatf("R4 %s slot chip %0d", tag, i), chip_slot[CW*i +: CW], es[i]);
    end
    chk($sformatf("R7 %s error flag", tag), cfg_err, ee);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int reads, dones, last_a;
    int zk[8];
    int ek[8];
    wipe();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    chk("R11 read strobe after reset", tbl_rd_en, 0);
    chk("R11 error after reset", cfg_err, 0);
    chk("R11 all chips free", int'(chip_kind), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 no read while idle", tbl_rd_en, 0);

    // stimulus vectors: R1 R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      load(v);
      run_walk(-1, reads, dones, last_a);
      chk($sformatf("R1 reads in vector %0d", v), reads, 8*(NENT[v] + 1));
      chk($sformatf("R1 last address in vector %0d", v), last_a, 8*(NENT[v] + 1) - 1);
      chk($sformatf("R10 done pulses in vector %0d", v), dones, 1);
      check_map($sformatf("vector %0d", v), EXP_K[v], EXP_R[v], EXP_S[v], EXP_E[v]);
    end

    // R8: address bytes rewritten, outcome unchanged
    load(0);
    for (int k = 0; k < NENT[0]; k++) mem[8*k + 6] = 8'hA5;
    run_walk(-1, reads, dones, last_a);
    check_map("R8 altered address", EXP_K[0], EXP_R[0], EXP_S[0], EXP_E[0]);

    // R9: terminator in the first entry, later entry never read; R10 clear
    wipe();
    put_ent(0, MMIO);
    put_ent(1, 64'h0A_00_01_00_08_00_00_00);
    run_walk(-1, reads, dones, last_a);
    chk("R9 reads with leading terminator", reads, 8);
    for (int i = 0; i < 8; i++) zk[i] = 0;
    check_map("R9 R10 empty table", zk, zk, zk, 0);

    // R9: sixteen-entry limit without terminator
    wipe();
    for (int k = 0; k < 15; k++) put_ent(k, 64'h0B_00_01_00_08_00_00_00);
    put_ent(15, 64'h0A_00_01_00_08_00_00_02);
    put_ent(16, 64'h0A_00_01_00_08_00_00_05);
    put_ent(17, MMIO);
    run_walk(-1, reads, dones, last_a);
    chk("R9 reads at entry limit", reads, 128);
    chk("R9 last address at entry limit", last_a, 127);
    for (int i = 0; i < 8; i++) ek[i] = (i == 2) ? 1 : 0;
    check_map("R9 entry limit", ek, zk, zk, 1);

    // R10: start during a walk is ignored, results then held
    load(1);
    run_walk(6, reads, dones, last_a);
    chk("R10 done pulses with second start", dones, 1);
    chk("R10 reads with second start", reads, 8*(NENT[1] + 1));
    check_map("R10 second start", EXP_K[1], EXP_R[1], EXP_S[1], EXP_E[1]);
    repeat (20) @(negedge clk);
    chk("R10 results held while idle", int'(chip_kind),
        int'(16'b00_10_00_10_01_01_01_01));
    chk("R10 busy low after walk", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule